// File: doc/BRIEF.md
# Single-Move CPU Sequencer

This block is the control core of an 8-bit processor that has exactly one operation. It copies a byte from one memory location to another, and it has no opcode field. Each instruction takes two bytes in a row. The byte at the program counter names the source location. The byte after it names the destination location. The sequencer reads both of those bytes, reads the source byte, and writes that byte to the destination. It then steps the program counter on by two.

Control flow comes only from side effects of the destination address. A store into the top four locations of the address space goes to the program counter as well as onto the bus:
- the highest location always loads the program counter;
- the other three load it only when the ALU carry, equality or greater-than flag is set.

Memory, the ALU and its flags sit outside this block. The block drives one shared address bus. It issues active-low read and write strobes and takes a read-data byte in.

Top module: `mv_core`

## Requirements
- R1: While reset is asserted, the address bus shows 0x00 and both strobes are high. After reset is released, the first read comes from address 0x00.
- R2: The first read of an instruction comes from the program counter (PC). The second read comes from PC+1, taken modulo 256. Before each of these reads, the same address is driven for one cycle with no strobe.
- R3: The third read uses the byte returned by the first read as its address.
- R4: The write strobe is low for exactly one cycle. During that cycle the address is the byte returned by the second read, and the write data is the byte returned by the third read. The write data does not change while the strobe is low.
- R5: The read and write strobes are never low in the same cycle. Each instruction takes exactly 8 clock cycles.
- R6: When the destination is any address other than 0xFC–0xFF, the next instruction starts at PC+2, modulo 256.
- R7: A destination of 0xFF always makes the written byte the next PC.
- R8: A destination of 0xFE makes the written byte the next PC when the carry flag is 1. Otherwise the next PC is PC+2.
- R9: A destination of 0xFD makes the written byte the next PC when the equal flag is 1. Otherwise the next PC is PC+2.
- R10: A destination of 0xFC makes the written byte the next PC when the greater-than flag is 1. Otherwise the next PC is PC+2.
- R11: If the synchronous clear is low at a clock edge, the sequencer returns to its first phase with PC = 0x00. This takes effect at any point in an instruction, and the next instruction starts at 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_n | input | 1 | Synchronous active-low clear |
| cond_carry | input | 1 | ALU carry flag, tested by a store to 0xFE |
| cond_eq | input | 1 | ALU equality flag, tested by a store to 0xFD |
| cond_gt | input | 1 | ALU greater-than flag, tested by a store to 0xFC |
| rd_data | input | 8 | Byte returned by memory or a device during a read |
| addr | output | 8 | Shared address bus |
| wr_data | output | 8 | Byte to be written |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |

## Verification
Every bus result belongs to a fixed phase of an 8-cycle instruction:
- the reads fall on cycles 1, 3 and 5 after the instruction starts;
- the write falls on cycle 7;
- the new PC shows on the address bus one cycle after the write, as the first address of the next instruction.

The bench steps through each instruction at falling edges and checks the address and strobes in every one of the eight cycles. It checks the next PC at the first cycle of the following instruction.

The sweep crosses every jump address and the ordinary destination with all eight flag combinations. It also covers a step from 0xFE that wraps to 0x00, and a clear issued in the middle of an instruction, which is checked one cycle later.

// File: rtl/mv_pkg.sv
`timescale 1ns/1ps
package mv_pkg;
  // Eight phases per move; odd phases carry a strobe.
  typedef enum logic [2:0] {
    PH_PC_SET  = 3'd0,
    PH_PC_RD   = 3'd1,
    PH_NX_SET  = 3'd2,
    PH_NX_RD   = 3'd3,
    PH_SRC_SET = 3'd4,
    PH_SRC_RD  = 3'd5,
    PH_DST_SET = 3'd6,
    PH_DST_WR  = 3'd7
  } phase_t;
endpackage

// File: rtl/mv_phase_gen.sv
`timescale 1ns/1ps
module mv_phase_gen
  import mv_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr_n,
  output phase_t phase_q
);
  phase_t phase_d;

  always_comb begin
    if (!clr_n) phase_d = PH_PC_SET;
    else        phase_d = phase_t'(phase_q + 3'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_PC_SET;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/mv_hold.sv
`timescale 1ns/1ps
module mv_hold
  import mv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  phase_t        phase,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] src_q,
  output logic [DW-1:0] dst_q,
  output logic [DW-1:0] dat_q
);
  logic          src_en, dst_en, dat_en;
  logic [DW-1:0] src_d, dst_d, dat_d;

  assign src_en = (phase == PH_PC_RD);
  assign dst_en = (phase == PH_NX_RD);
  assign dat_en = (phase == PH_SRC_RD);

  always_comb begin
    src_d = src_q;
    dst_d = dst_q;
    dat_d = dat_q;
    if (!clr_n) begin
      src_d = '0;
      dst_d = '0;
      dat_d = '0;
    end else begin
      if (src_en) src_d = rd_data;
      if (dst_en) dst_d = rd_data;
      if (dat_en) dat_d = rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      dat_q <= '0;
    end else begin
      src_q <= src_d;
      dst_q <= dst_d;
      dat_q <= dat_d;
    end
  end
endmodule

// File: rtl/mv_jump_dec.sv
`timescale 1ns/1ps
module mv_jump_dec #(
  parameter int DW        = 8,
  parameter bit CMP_JUMPS = 1'b1
) (
  input  logic [DW-1:0] dst,
  input  logic          cond_carry,
  input  logic          cond_eq,
  input  logic          cond_gt,
  output logic          in_window,
  output logic          take
);
  localparam int HI = DW - 1;
  logic [3:0] cond_vec;

  // Index = low two destination bits: 3 always, 2 carry, 1 equal, 0 greater.
  generate
    if (CMP_JUMPS) begin : g_cmp
      assign cond_vec = {1'b1, cond_carry, cond_eq, cond_gt};
    end else begin : g_nocmp
      assign cond_vec = {1'b1, cond_carry, 2'b00};
    end
  endgenerate

  assign in_window = &dst[HI:2];
  assign take      = in_window & cond_vec[dst[1:0]];
endmodule

// File: rtl/mv_pc.sv
`timescale 1ns/1ps
module mv_pc
  import mv_pkg::*;
#(
  parameter int          DW       = 8,
  parameter logic [DW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  phase_t        phase,
  input  logic          take,
  input  logic [DW-1:0] target,
  output logic [DW-1:0] pc_q,
  output logic [DW-1:0] pc_inc1
);
  localparam logic [DW-1:0] STEP = DW'(2);
  logic [DW-1:0] pc_d;
  logic          pc_en;

  assign pc_en   = (phase == PH_DST_WR);
  assign pc_inc1 = pc_q + DW'(1);

  always_comb begin
    pc_d = pc_q;
    if (!clr_n)      pc_d = RESET_PC;
    else if (pc_en)  pc_d = take ? target : pc_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RESET_PC;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/mv_core.sv
`timescale 1ns/1ps
module mv_core
  import mv_pkg::*;
#(
  parameter int            DW        = 8,
  parameter logic [DW-1:0] RESET_PC  = '0,
  parameter bit            CMP_JUMPS = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_n,
  input  logic          cond_carry,
  input  logic          cond_eq,
  input  logic          cond_gt,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] addr,
  output logic [DW-1:0] wr_data,
  output logic          rd_n,
  output logic          wr_n
);
  phase_t        phase_q;
  logic [DW-1:0] src_q, dst_q, dat_q;
  logic [DW-1:0] pc_q, pc_inc1;
  logic          jmp_win, jmp_take;

  mv_phase_gen u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .phase_q (phase_q)
  );

  mv_hold #(.DW(DW)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .phase   (phase_q),
    .rd_data (rd_data),
    .src_q   (src_q),
    .dst_q   (dst_q),
    .dat_q   (dat_q)
  );

  mv_jump_dec #(.DW(DW), .CMP_JUMPS(CMP_JUMPS)) u_jdec (
    .dst        (dst_q),
    .cond_carry (cond_carry),
    .cond_eq    (cond_eq),
    .cond_gt    (cond_gt),
    .in_window  (jmp_win),
    .take       (jmp_take)
  );

  mv_pc #(.DW(DW), .RESET_PC(RESET_PC)) u_pc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_n   (clr_n),
    .phase   (phase_q),
    .take    (jmp_take),
    .target  (dat_q),
    .pc_q    (pc_q),
    .pc_inc1 (pc_inc1)
  );

  // Bus ownership: PC for phases 0-3, holding registers for 4-7.
  always_comb begin
    unique case (phase_q)
      PH_PC_SET,  PH_PC_RD:  addr = pc_q;
      PH_NX_SET,  PH_NX_RD:  addr = pc_inc1;
      PH_SRC_SET, PH_SRC_RD: addr = src_q;
      default:               addr = dst_q;
    endcase
  end

  assign rd_n    = !((phase_q == PH_PC_RD) || (phase_q == PH_NX_RD) ||
                     (phase_q == PH_SRC_RD));
  assign wr_n    = !(phase_q == PH_DST_WR);
  assign wr_data = dat_q;

  logic unused_win;
  assign unused_win = jmp_win;
endmodule

// File: rtl/mv_core_chk.sv
`timescale 1ns/1ps
module mv_core_chk #(
  parameter int            DW       = 8,
  parameter logic [DW-1:0] RESET_PC = '0
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_n,
  input logic [2:0]    phase,
  input logic [DW-1:0] pc,
  input logic [DW-1:0] addr,
  input logic [DW-1:0] wr_data,
  input logic          rd_n,
  input logic          wr_n,
  input logic          cond_carry
);
  localparam logic [DW-3:0] TOP = '1;

  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  a_r4_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> wr_n);

  a_r4_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> $stable(wr_data));

  a_r2_code_at_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd1) |-> (addr == pc && !rd_n));

  a_r2_dst_at_pc1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd3) |-> (addr == DW'(pc + DW'(1))));

  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd7 && clr_n && addr[DW-1:2] != TOP) |=> pc == $past(pc) + DW'(2));

  a_r7_uncond: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd7 && clr_n && &addr) |=> pc == $past(wr_data));

  a_r8_carry_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd7 && clr_n && addr == {TOP, 2'b10} && !cond_carry)
      |=> pc == $past(pc) + DW'(2));

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (pc == RESET_PC && phase == 3'd0));
endmodule

bind mv_core mv_core_chk #(.DW(DW), .RESET_PC(RESET_PC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_n      (clr_n),
  .phase      (phase_q),
  .pc         (pc_q),
  .addr       (addr),
  .wr_data    (wr_data),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .cond_carry (cond_carry)
);

// File: tb/mv_core_bench.sv
`timescale 1ns/1ps
module mv_core_bench;
  logic       clk = 1'b0;
  logic       rst_n, clr_n;
  logic       cond_carry, cond_eq, cond_gt;
  logic [7:0] rd_data, addr, wr_data;
  logic       rd_n, wr_n;
  logic [7:0] mem [256];
  logic [7:0] pc_exp;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  mv_core u_mv_core (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n),
    .cond_carry(cond_carry), .cond_eq(cond_eq), .cond_gt(cond_gt),
    .rd_data(rd_data), .addr(addr), .wr_data(wr_data),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  assign rd_data = mem[addr];

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // Called at the falling edge of phase 0; returns at phase 0 of the next move.
  task automatic do_move(input logic [7:0] dst, input logic [7:0] val,
                         input logic [2:0] flags, input string tag);
    logic [7:0] src, pc1, nxt, a_exp;
    logic       taken;
    src = pc_exp ^ 8'h80;
    pc1 = pc_exp + 8'd1;
    mem[pc_exp] = src;
    mem[pc1]    = dst;
    mem[src]    = val;
    cond_gt    = flags[0];
    cond_eq    = flags[1];
    cond_carry = flags[2];
    taken = (dst == 8'hFF) || (dst == 8'hFE && flags[2]) ||
            (dst == 8'hFD && flags[1]) || (dst == 8'hFC && flags[0]);
    nxt = taken ? val : pc_exp + 8'd2;
    for (int ph = 0; ph < 8; ph++) begin
      a_exp = (ph < 2) ? pc_exp : (ph < 4) ? pc1 : (ph < 6) ? src : dst;
      if (ph < 4)      chk("R2 address", addr, a_exp);
      else if (ph < 6) chk("R3 address", addr, a_exp);
      else             chk("R4 address", addr, a_exp);
      chk("R5 strobes", {6'd0, rd_n, wr_n},
          {6'd0, !(ph == 1 || ph == 3 || ph == 5), !(ph == 7)});
      if (ph == 7) chk("R4 write data", wr_data, val);
      @(negedge clk);
    end
    chk(tag, addr, nxt);
    pc_exp = nxt;
  endtask

  initial begin
    logic [7:0] d, v;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst_n = 1'b0; clr_n = 1'b1;
    cond_carry = 1'b0; cond_eq = 1'b0; cond_gt = 1'b0;
    pc_exp = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset address", addr, 8'h00);
    chk("R1 reset strobes", {6'd0, rd_n, wr_n}, 8'h03);
    rst_n = 1'b1;
    // Sweep destination kinds against all flag combinations.
    for (int rep = 0; rep < 2; rep++) begin
      for (int k = 0; k < 5; k++) begin
        for (int f = 0; f < 8; f++) begin
          v = 8'(rep * 83 + k * 29 + f * 11 + 7);
          if (k == 4) begin
            d = pc_exp ^ 8'h40;
            if (d >= 8'hFC) d = d - 8'h10;
            do_move(d, v, 3'(f), "R6 next pc");
          end else begin
            d = 8'hFC + 8'(k);
            case (k)
              0: do_move(d, v, 3'(f), "R10 next pc");
              1: do_move(d, v, 3'(f), "R9 next pc");
              2: do_move(d, v, 3'(f), "R8 next pc");
              default: do_move(d, v, 3'(f), "R7 next pc");
            endcase
          end
        end
      end
    end
    // Wrap: jump to 0xFE, then an ordinary move steps to 0x00.
    do_move(8'hFF, 8'hFE, 3'd0, "R7 next pc");
    do_move(8'h10, 8'h5A, 3'd0, "R6 wrap");
    do_move(8'h20, 8'hA5, 3'd7, "R6 after wrap");
    // Clear in the middle of a move.
    repeat (4) @(negedge clk);
    clr_n = 1'b0;
    @(negedge clk);
    chk("R11 clear address", addr, 8'h00);
    chk("R11 clear strobes", {6'd0, rd_n, wr_n}, 8'h03);
    clr_n = 1'b1;
    pc_exp = 8'h00;
    do_move(8'h33, 8'h44, 3'd0, "R11 restart");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule